// File: doc/BRIEF.md
# UART Interrupt Cause Arbiter

This block merges the interrupt sources of a serial port into one interrupt line and a registered identification word. The host reads that word to learn which cause to service first. The sources are:

- receiver line errors;
- receive data at or above a fill threshold;
- a stale-data timeout on the receive queue;
- transmit holding space becoming empty;
- changes on the four modem control inputs.

Each cause is gated by its own enable bit. Each cause is also retired by its own kind of host access. The register decode, the receive queue and the serial shifters sit outside the block. They reach it as level, strobe and access-pulse inputs.

Internally, each cause keeps its own state: sticky error flags, sticky modem deltas, a transmit-empty flag, a stale-data timer and a registered threshold compare. A fixed priority encoder turns these states into the identification outputs. Every output is registered. A cause seen on the inputs in one cycle therefore appears on the outputs two clock edges later.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `irq` is 0, `iir_pend_n` is 1, `iir_id` is 000, `iir_fifo_bits` is 00, and `lsr_err` and `msr_delta` are zero.
- R2: A cause contributes only when its enable bit is set. The `ier_en` bits are: bit0 receive data and timeout, bit1 transmit empty, bit2 line error, bit3 modem change. `irq` is 1 exactly when some enabled cause is active, and `iir_pend_n` is always its inverse.
- R3: When several enabled causes are active, `iir_id` reports the first of these, in this order: line error 011; receive data 010; stale timeout 110; transmit empty 001; modem change 000. With no cause active, `iir_id` is 000.
- R4: Bits of `line_err` are sticky in `lsr_err`: bit0 overrun, bit1 parity, bit2 framing, bit3 break. A `lsr_rd` pulse clears them. A bit set in the same cycle as `lsr_rd` survives.
- R5: Receive data is active while `rx_level` is at or above the threshold. With `fifo_en` set, the threshold is 1, 4, 8 or 14 words for `trig_sel` 00, 01, 10 or 11. With `fifo_en` clear, the threshold is 1.
- R6: With `fifo_en` set and `rx_level` nonzero, the stale timeout becomes active after four `char_tick` pulses with no `rx_push` or `rx_pop`. A push or pop restarts the count and clears an active timeout. An empty queue does the same.
- R7: A `thre_evt` pulse sets the transmit-empty cause. A `thr_wr` pulse clears it.
- R8: An `iir_rd` pulse clears the transmit-empty cause only while `iir_id` shows 001. Otherwise it leaves that cause set.
- R9: `msr_delta` holds sticky change flags: bit0 any change on `cts_in`, bit1 any change on `dsr_in`, bit2 a 0-to-1 edge on `ri_in`, bit3 any change on `dcd_in`. A `msr_rd` pulse clears them. A 1-to-0 edge on `ri_in` sets nothing.
- R10: `iir_fifo_bits` reads 11 while `fifo_en` is set and 00 otherwise.
- R11: A cause raised by an input in one cycle appears on `irq` and `iir_id` after the second following clock edge, not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Queued mode select |
| trig_sel | input | 2 | Receive threshold select |
| ier_en | input | 4 | Per-cause enable bits |
| rx_level | input | LVLW | Receive queue fill count |
| rx_push | input | 1 | A word entered the receive queue |
| rx_pop | input | 1 | Host read a received word |
| char_tick | input | 1 | One pulse per character time |
| line_err | input | 4 | Line error event pulses |
| lsr_rd | input | 1 | Host read of line status |
| thre_evt | input | 1 | Transmit holding space became empty |
| thr_wr | input | 1 | Host write of transmit data |
| iir_rd | input | 1 | Host read of the identification word |
| cts_in | input | 1 | Clear-to-send input level |
| dsr_in | input | 1 | Data-set-ready input level |
| dcd_in | input | 1 | Carrier-detect input level |
| ri_in | input | 1 | Ring input level |
| msr_rd | input | 1 | Host read of modem status |
| irq | output | 1 | Interrupt request |
| iir_pend_n | output | 1 | Active-low pending flag |
| iir_id | output | 3 | Highest-priority cause code |
| iir_fifo_bits | output | 2 | Queued-mode indication bits |
| lsr_err | output | 4 | Sticky line error flags |
| msr_delta | output | 4 | Sticky modem change flags |

## Verification
A wrong priority order, or a wrongly gated enable, shows as a wrong `iir_id` or `irq` two edges after the causes are applied. The stimulus table sets up overlapping causes to expose exactly that. A stale-timer count that drifts shows as a timeout that is early or late by a whole character tick. A clear that acts on the wrong access shows as a cause that survives or vanishes after the access. In both cases the bench looks two edges after the stimulus. Sticky flags that set or clear wrongly are visible directly on `lsr_err` and `msr_delta` one edge after the event.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    ID_MODEM = 3'b000,
    ID_THRE  = 3'b001,
    ID_RDA   = 3'b010,
    ID_LINE  = 3'b011,
    ID_TMO   = 3'b110
  } irq_id_e;

  localparam int EN_RDA   = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  // receive threshold in words; a single word when not queued
  function automatic logic [3:0] trig_words(input logic queued, input logic [1:0] sel);
    logic [3:0] w;
    if (!queued) begin
      w = 4'd1;
    end else begin
      case (sel)
        2'b00:   w = 4'd1;
        2'b01:   w = 4'd4;
        2'b10:   w = 4'd8;
        default: w = 4'd14;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/irq_sticky.sv
module irq_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (clr ? '0 : q) | set;
  end

  // R4 R7
  sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && set == '0) |=> q == '0);

  // R4
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((q & $past(set)) == $past(set)));

endmodule

// File: rtl/irq_rx_timer.sv
module irq_rx_timer #(
  parameter int LVLW      = 5,
  parameter int TMO_CHARS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fifo_on,
  input  logic [LVLW-1:0] rx_level,
  input  logic            rx_push,
  input  logic            rx_pop,
  input  logic            char_tick,
  output logic            tmo
);

  localparam int CW = $clog2(TMO_CHARS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TMO_CHARS);

  logic [CW-1:0] cnt_q;
  logic          restart;

  assign restart = !fifo_on || (rx_level == '0) || rx_push || rx_pop;

  always_ff @(posedge clk) begin
    if (rst)                                cnt_q <= '0;
    else if (restart)                       cnt_q <= '0;
    else if (char_tick && cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
  end

  assign tmo = (cnt_q == LIMIT);

  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);

  // R6
  tmo_pop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !tmo);

endmodule

// File: rtl/irq_modem_delta.sv
module irq_modem_delta (
  input  logic       clk,
  input  logic       rst,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       ri_in,
  input  logic       dcd_in,
  input  logic       msr_rd,
  output logic [3:0] delta
);

  logic [3:0] pins;
  logic [3:0] prev_q;
  logic       primed_q;
  logic [3:0] chg;
  logic [3:0] delta_q;

  assign pins = {dcd_in, ri_in, dsr_in, cts_in};

  always_comb begin
    chg = '0;
    if (primed_q) begin
      chg[0] = pins[0] ^ prev_q[0];
      chg[1] = pins[1] ^ prev_q[1];
      chg[2] = pins[2] & ~prev_q[2];
      chg[3] = pins[3] ^ prev_q[3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      delta_q  <= '0;
    end else begin
      prev_q   <= pins;
      primed_q <= 1'b1;
      delta_q  <= (msr_rd ? 4'b0 : delta_q) | chg;
    end
  end

  assign delta = delta_q;

  // R9
  ri_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (primed_q && ri_in && !prev_q[2]) |=> delta_q[2]);

  // R9
  ri_fall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (primed_q && msr_rd && !ri_in && prev_q[2]) |=> !delta_q[2]);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fifo_on,
  input  logic [3:0] en,
  input  logic       line_act,
  input  logic       rda_act,
  input  logic       tmo_act,
  input  logic       thre_act,
  input  logic       modem_act,
  output logic       irq_q,
  output logic       pend_n_q,
  output logic [2:0] id_q,
  output logic [1:0] fifo_bits_q
);

  irq_id_e id_d;
  logic    any_d;

  always_comb begin
    any_d = 1'b1;
    if (en[EN_LINE] && line_act)        id_d = ID_LINE;
    else if (en[EN_RDA] && rda_act)     id_d = ID_RDA;
    else if (en[EN_RDA] && tmo_act)     id_d = ID_TMO;
    else if (en[EN_THRE] && thre_act)   id_d = ID_THRE;
    else if (en[EN_MODEM] && modem_act) id_d = ID_MODEM;
    else begin
      id_d  = ID_MODEM;
      any_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q       <= 1'b0;
      pend_n_q    <= 1'b1;
      id_q        <= 3'b000;
      fifo_bits_q <= 2'b00;
    end else begin
      irq_q       <= any_d;
      pend_n_q    <= ~any_d;
      id_q        <= id_d;
      fifo_bits_q <= {2{fifo_on}};
    end
  end

  // R3
  line_first_chk: assert property (@(posedge clk) disable iff (rst)
    (en[EN_LINE] && line_act) |=> (id_q == 3'b011 && irq_q));

  // R2
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (en == 4'b0000) |=> (!irq_q && pend_n_q));

  // R10
  fifo_bits_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_on |=> fifo_bits_q == 2'b11);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TMO_CHARS  = 4,
  parameter int LVLW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fifo_en,
  input  logic [1:0]      trig_sel,
  input  logic [3:0]      ier_en,
  input  logic [LVLW-1:0] rx_level,
  input  logic            rx_push,
  input  logic            rx_pop,
  input  logic            char_tick,
  input  logic [3:0]      line_err,
  input  logic            lsr_rd,
  input  logic            thre_evt,
  input  logic            thr_wr,
  input  logic            iir_rd,
  input  logic            cts_in,
  input  logic            dsr_in,
  input  logic            dcd_in,
  input  logic            ri_in,
  input  logic            msr_rd,
  output logic            irq,
  output logic            iir_pend_n,
  output logic [2:0]      iir_id,
  output logic [1:0]      iir_fifo_bits,
  output logic [3:0]      lsr_err,
  output logic [3:0]      msr_delta
);

  logic [3:0]      err_q;
  logic [0:0]      thre_q;
  logic            thre_clr;
  logic            tmo;
  logic            rda_q;
  logic [LVLW-1:0] trig_lvl;
  logic [3:0]      delta;
  logic [2:0]      id_w;

  assign trig_lvl = LVLW'(trig_words(fifo_en, trig_sel));

  always_ff @(posedge clk) begin
    if (rst) rda_q <= 1'b0;
    else     rda_q <= (rx_level >= trig_lvl);
  end

  irq_sticky #(.W(4)) u_err (
    .clk (clk),
    .rst (rst),
    .set (line_err),
    .clr (lsr_rd),
    .q   (err_q)
  );

  assign thre_clr = thr_wr || (iir_rd && id_w == ID_THRE);

  irq_sticky #(.W(1)) u_thre (
    .clk (clk),
    .rst (rst),
    .set (thre_evt),
    .clr (thre_clr),
    .q   (thre_q)
  );

  irq_rx_timer #(.LVLW(LVLW), .TMO_CHARS(TMO_CHARS)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .fifo_on   (fifo_en),
    .rx_level  (rx_level),
    .rx_push   (rx_push),
    .rx_pop    (rx_pop),
    .char_tick (char_tick),
    .tmo       (tmo)
  );

  irq_modem_delta u_mdm (
    .clk    (clk),
    .rst    (rst),
    .cts_in (cts_in),
    .dsr_in (dsr_in),
    .ri_in  (ri_in),
    .dcd_in (dcd_in),
    .msr_rd (msr_rd),
    .delta  (delta)
  );

  irq_prio_enc u_enc (
    .clk         (clk),
    .rst         (rst),
    .fifo_on     (fifo_en),
    .en          (ier_en),
    .line_act    (|err_q),
    .rda_act     (rda_q),
    .tmo_act     (tmo),
    .thre_act    (thre_q[0]),
    .modem_act   (|delta),
    .irq_q       (irq),
    .pend_n_q    (iir_pend_n),
    .id_q        (id_w),
    .fifo_bits_q (iir_fifo_bits)
  );

  assign iir_id    = id_w;
  assign lsr_err   = err_q;
  assign msr_delta = delta;

  // R8
  thre_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (thre_q[0] && iir_rd && id_w != 3'b001 && !thr_wr) |=> thre_q[0]);

  // R7
  thre_wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_wr && !thre_evt) |=> !thre_q[0]);

endmodule

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;

  localparam int LVLW = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            fifo_en = 1'b0;
  logic [1:0]      trig_sel = 2'b00;
  logic [3:0]      ier_en = 4'b0;
  logic [LVLW-1:0] rx_level = '0;
  logic            rx_push = 1'b0, rx_pop = 1'b0, char_tick = 1'b0;
  logic [3:0]      line_err = 4'b0;
  logic            lsr_rd = 1'b0, thre_evt = 1'b0, thr_wr = 1'b0, iir_rd = 1'b0;
  logic            cts_in = 1'b0, dsr_in = 1'b0, dcd_in = 1'b0, ri_in = 1'b0;
  logic            msr_rd = 1'b0;
  logic            irq, iir_pend_n;
  logic [2:0]      iir_id;
  logic [1:0]      iir_fifo_bits;
  logic [3:0]      lsr_err, msr_delta;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .ier_en(ier_en), .rx_level(rx_level), .rx_push(rx_push), .rx_pop(rx_pop),
    .char_tick(char_tick), .line_err(line_err), .lsr_rd(lsr_rd),
    .thre_evt(thre_evt), .thr_wr(thr_wr), .iir_rd(iir_rd),
    .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in), .ri_in(ri_in),
    .msr_rd(msr_rd), .irq(irq), .iir_pend_n(iir_pend_n), .iir_id(iir_id),
    .iir_fifo_bits(iir_fifo_bits), .lsr_err(lsr_err), .msr_delta(msr_delta)
  );

  // {ier, err, level, thre, modem, exp_irq, exp_id}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {4'b1111, 4'b0001, 5'd1, 1'b1, 1'b1, 1'b1, 3'b011},
    {4'b1111, 4'b0000, 5'd1, 1'b1, 1'b1, 1'b1, 3'b010},
    {4'b1111, 4'b0000, 5'd0, 1'b1, 1'b1, 1'b1, 3'b001},
    {4'b1111, 4'b0000, 5'd0, 1'b0, 1'b1, 1'b1, 3'b000},
    {4'b1111, 4'b0000, 5'd0, 1'b0, 1'b0, 1'b0, 3'b000},
    {4'b1011, 4'b0100, 5'd1, 1'b0, 1'b0, 1'b1, 3'b010},
    {4'b0000, 4'b1111, 5'd1, 1'b1, 1'b1, 1'b0, 3'b000},
    {4'b1000, 4'b0010, 5'd0, 1'b1, 1'b1, 1'b1, 3'b000},
    {4'b0010, 4'b1000, 5'd1, 1'b1, 1'b0, 1'b1, 3'b001},
    {4'b0100, 4'b1000, 5'd0, 1'b0, 1'b0, 1'b1, 3'b011}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic e_irq, input logic [2:0] e_id);
    check(tag, {7'b0, irq}, {7'b0, e_irq});
    check(tag, {7'b0, iir_pend_n}, {7'b0, ~e_irq});
    check(tag, {5'b0, iir_id}, {5'b0, e_id});
  endtask

  // clears all sticky causes and empties the queue for one cycle
  task automatic clear_all();
    lsr_rd = 1'b1; msr_rd = 1'b1; thr_wr = 1'b1; rx_level = '0;
    @(negedge clk);
    lsr_rd = 1'b0; msr_rd = 1'b0; thr_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      char_tick = 1'b1; @(negedge clk);
      char_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic rda_case(input logic q, input logic [1:0] s, input int lvl, input logic e);
    fifo_en = q; trig_sel = s; rx_level = LVLW'(lvl);
    settle();
    check("R5 threshold irq", {7'b0, irq}, {7'b0, e});
    if (e) check("R5 threshold id", {5'b0, iir_id}, 8'h02);
    check("R10 fifo bits", {6'b0, iir_fifo_bits}, q ? 8'h03 : 8'h00);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_out("R1 reset", 1'b0, 3'b000);
    check("R1 fifo bits", {6'b0, iir_fifo_bits}, 8'h00);
    check("R1 lsr_err", {4'b0, lsr_err}, 8'h00);
    check("R1 msr_delta", {4'b0, msr_delta}, 8'h00);

    // R2 R3 priority table, threshold one word
    fifo_en = 1'b1; trig_sel = 2'b00;
    for (int i = 0; i < NV; i++) begin
      ier_en = VEC[i][18:15];
      clear_all();
      line_err = VEC[i][14:11];
      rx_level = VEC[i][10:6];
      thre_evt = VEC[i][5];
      if (VEC[i][4]) cts_in = ~cts_in;
      @(negedge clk);
      line_err = 4'b0; thre_evt = 1'b0;
      @(negedge clk);
      chk_out($sformatf("R3 R2 vector %0d", i), VEC[i][3], VEC[i][2:0]);
    end

    // R5 thresholds
    ier_en = 4'b0001;
    clear_all();
    rda_case(1'b1, 2'b01, 3, 1'b0);
    rda_case(1'b1, 2'b01, 4, 1'b1);
    rda_case(1'b1, 2'b10, 7, 1'b0);
    rda_case(1'b1, 2'b10, 8, 1'b1);
    rda_case(1'b1, 2'b11, 13, 1'b0);
    rda_case(1'b1, 2'b11, 14, 1'b1);
    rda_case(1'b0, 2'b11, 1, 1'b1);
    rda_case(1'b0, 2'b11, 0, 1'b0);

    // R6 stale timeout
    fifo_en = 1'b1; trig_sel = 2'b11;
    clear_all();
    rx_level = 5'd2;
    ticks(3);
    @(negedge clk);
    check("R6 three ticks quiet", {7'b0, irq}, 8'h00);
    ticks(1);
    chk_out("R6 timeout after four", 1'b1, 3'b110);
    rx_pop = 1'b1; rx_level = 5'd1; @(negedge clk);
    rx_pop = 1'b0; @(negedge clk);
    check("R6 pop clears", {7'b0, irq}, 8'h00);
    ticks(3);
    rx_push = 1'b1; rx_level = 5'd2; @(negedge clk);
    rx_push = 1'b0;
    ticks(1);
    @(negedge clk);
    check("R6 push restarts", {7'b0, irq}, 8'h00);
    ticks(3);
    chk_out("R6 timeout after restart", 1'b1, 3'b110);
    rx_level = '0;
    settle();
    check("R6 empty clears", {7'b0, irq}, 8'h00);

    // R7 R8 transmit empty
    ier_en = 4'b0010;
    clear_all();
    thre_evt = 1'b1; @(negedge clk); thre_evt = 1'b0; @(negedge clk);
    chk_out("R7 thre set", 1'b1, 3'b001);
    thr_wr = 1'b1; @(negedge clk); thr_wr = 1'b0; @(negedge clk);
    check("R7 write clears", {7'b0, irq}, 8'h00);
    thre_evt = 1'b1; @(negedge clk); thre_evt = 1'b0; @(negedge clk);
    iir_rd = 1'b1; @(negedge clk); iir_rd = 1'b0; @(negedge clk);
    check("R8 id read clears", {7'b0, irq}, 8'h00);
    ier_en = 4'b0110;
    thre_evt = 1'b1; line_err = 4'b0001; @(negedge clk);
    thre_evt = 1'b0; line_err = 4'b0; @(negedge clk);
    chk_out("R8 line shown", 1'b1, 3'b011);
    iir_rd = 1'b1; @(negedge clk); iir_rd = 1'b0; @(negedge clk);
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0; @(negedge clk);
    chk_out("R8 thre kept", 1'b1, 3'b001);

    // R4 R11 line errors
    ier_en = 4'b0100;
    clear_all();
    line_err = 4'b0101; @(negedge clk); line_err = 4'b0;
    check("R4 sticky flags", {4'b0, lsr_err}, 8'h05);
    check("R11 not after one edge", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk_out("R11 after two edges", 1'b1, 3'b011);
    lsr_rd = 1'b1; line_err = 4'b0010; @(negedge clk);
    lsr_rd = 1'b0; line_err = 4'b0;
    check("R4 set beats clear", {4'b0, lsr_err}, 8'h02);
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0; @(negedge clk);
    check("R4 read clears", {4'b0, lsr_err}, 8'h00);
    check("R4 irq drops", {7'b0, irq}, 8'h00);

    // R9 modem deltas
    ier_en = 4'b1000;
    clear_all();
    ri_in = 1'b1; settle();
    check("R9 ri rise", {4'b0, msr_delta}, 8'h04);
    chk_out("R9 modem irq", 1'b1, 3'b000);
    msr_rd = 1'b1; @(negedge clk); msr_rd = 1'b0;
    ri_in = 1'b0; settle();
    check("R9 ri fall ignored", {4'b0, msr_delta}, 8'h00);
    check("R9 irq quiet", {7'b0, irq}, 8'h00);
    dsr_in = ~dsr_in; @(negedge clk);
    dcd_in = ~dcd_in; @(negedge clk);
    check("R9 dsr dcd", {4'b0, msr_delta}, 8'h0A);
    cts_in = ~cts_in; @(negedge clk);
    check("R9 cts", {4'b0, msr_delta}, 8'h0B);
    msr_rd = 1'b1; @(negedge clk); msr_rd = 1'b0; @(negedge clk);
    check("R9 read clears", {4'b0, msr_delta}, 8'h00);

    report();
  end

endmodule